// File: doc/BRIEF.md
# Accumulator Processor Fetch-Execute Controller

A small multicycle processor core built around a single accumulator. It runs one instruction at a time through a fixed sequence of phases: instruction fetch, decode and execute. No memory access happens except through two holding registers, an address latch and a data latch. A fetched word is copied into an instruction register, and the decode and execute phases work from that copy. The core talks to one single-port synchronous memory. Reads return data one clock after the address is presented. Writes take effect at the clock edge that ends the write cycle.

Software sets a start address and pulses the start strobe while the core is halted. The core then fetches from that address and keeps running until it executes a halt instruction, which stops it and raises the halted output again. An interrupt request input is latched whenever it is seen. The latch is only examined at the boundary between two instructions. At that boundary a one-cycle acknowledge pulse is produced and the latch is cleared.

Top module: `acc_cpu`

## Requirements
- R1: Every fetch presents the program counter's value on `mem_addr` in the second cycle of the instruction. The word returned is moved through the data latch into the instruction register before decode.
- R2: The program counter advances by one during fetch, so the next sequential instruction is fetched from the following address.
- R3: An instruction word carries the opcode in bits 15:12 and a 12-bit operand address in bits 11:0. The full 12-bit operand appears on `mem_addr` when the operand is accessed. Opcodes: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-negative.
- R4: Load copies the word at the operand address into the accumulator.
- R5: Store writes the accumulator to the operand address and touches no other address.
- R6: Add and subtract combine the accumulator with the word at the operand address, modulo 2^16, and put the result in the accumulator.
- R7: Only add and subtract update the status flags: carry, zero, negative (result bit 15) and signed overflow. Load, store, jumps and unused opcodes leave the flags unchanged.
- R8: Jump always sets the program counter to the operand. Jump-if-negative does so only when the negative flag is set, and otherwise falls through to the next address.
- R9: After reset the core is halted. A start strobe while halted loads `start_addr` into the program counter, and `halted` is low from the next cycle. Opcode 0 halts the core. A strobe while the core is running has no effect.
- R10: An interrupt request pulse is latched and acknowledged once, in the last cycle of the instruction during which it arrived. A request that arrives in that last cycle is acknowledged at the end of the following instruction.
- R11: Opcodes 7 to 15 do nothing except consume their cycles.
- R12: Instruction lengths are fixed: load, add and subtract take 9 cycles, store takes 7, jumps and no-ops take 6. `halted` rises 6 cycles after a halt instruction's fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, honoured only while halted |
| start_addr | input | 12 | First instruction address |
| irq | input | 1 | Interrupt request |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| mem_addr | output | 12 | Memory address (address latch) |
| mem_wdata | output | 16 | Memory write data (data latch) |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Core is stopped and waiting for start |
| irq_ack | output | 1 | Interrupt taken at an instruction boundary |

## Verification
Cycle 1 is the cycle that follows the clock edge that accepts the start strobe. Counting from there, the instruction fetch address is due in cycle 2. The load operand address is due in cycle 6. The second fetch address is due in cycle 11. The acknowledge for a request raised in cycle 2 is due in cycle 9, and for one raised in cycle 9 it is due in cycle 18. The halt cycle of each program follows from the per-instruction lengths. The bench counts clock edges from the start strobe, samples every output on the falling edge at exactly those counts, and derives each program's expected halt cycle by summing the instruction lengths along the path that the branch outcome selects.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_JMP   = 4'h5;
  localparam logic [3:0] OP_JMN   = 4'h6;

  typedef enum logic [3:0] {
    PH_HALT,
    PH_FADDR,
    PH_FREAD,
    PH_FMDR,
    PH_FCIR,
    PH_DECODE,
    PH_EREAD,
    PH_EMDR,
    PH_EXEC,
    PH_EWRITE,
    PH_END
  } phase_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  typedef struct packed {
    logic pc_start;
    logic pc_inc;
    logic pc_jmp;
    logic mar_pc;
    logic mar_opnd;
    logic mdr_mem;
    logic mdr_acc;
    logic cir_ld;
    logic acc_mem;
    logic acc_alu;
    logic flag_ld;
    logic alu_sub;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output flags_t       fl
);

  logic [W-1:0] b_op;
  logic [W:0]   sum;

  always_comb begin
    b_op = sub ? ~b : b;
    sum  = {1'b0, a} + {1'b0, b_op} + {{W{1'b0}}, sub};
    res  = sum[W-1:0];
    fl.c = sum[W];
    fl.z = (sum[W-1:0] == '0);
    fl.n = sum[W-1];
    fl.v = (a[W-1] == b_op[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            irq,
  input  logic            neg_flag,
  input  logic [OP_W-1:0] op,
  output ctl_t            ctl,
  output logic            mem_we,
  output logic            halted,
  output logic            irq_ack
);

  phase_e ph, ph_nxt;
  logic   pend, pend_nxt;

  logic is_load, is_store, is_add, is_sub, is_jmp, is_jmn, is_halt;

  always_comb begin
    is_halt  = (op == OP_W'(OP_HALT));
    is_load  = (op == OP_W'(OP_LOAD));
    is_store = (op == OP_W'(OP_STORE));
    is_add   = (op == OP_W'(OP_ADD));
    is_sub   = (op == OP_W'(OP_SUB));
    is_jmp   = (op == OP_W'(OP_JMP));
    is_jmn   = (op == OP_W'(OP_JMN));
  end

  // next-state and control decode
  always_comb begin
    ph_nxt = ph;
    ctl    = '0;
    mem_we = 1'b0;
    unique case (ph)
      PH_HALT: begin
        if (start) begin
          ctl.pc_start = 1'b1;
          ph_nxt       = PH_FADDR;
        end
      end
      PH_FADDR: begin
        ctl.mar_pc = 1'b1;
        ctl.pc_inc = 1'b1;
        ph_nxt     = PH_FREAD;
      end
      PH_FREAD: ph_nxt = PH_FMDR;
      PH_FMDR: begin
        ctl.mdr_mem = 1'b1;
        ph_nxt      = PH_FCIR;
      end
      PH_FCIR: begin
        ctl.cir_ld = 1'b1;
        ph_nxt     = PH_DECODE;
      end
      PH_DECODE: begin
        if (is_halt) begin
          ph_nxt = PH_HALT;
        end else if (is_load || is_add || is_sub) begin
          ctl.mar_opnd = 1'b1;
          ph_nxt       = PH_EREAD;
        end else if (is_store) begin
          ctl.mar_opnd = 1'b1;
          ctl.mdr_acc  = 1'b1;
          ph_nxt       = PH_EWRITE;
        end else if (is_jmp) begin
          ctl.pc_jmp = 1'b1;
          ph_nxt     = PH_END;
        end else if (is_jmn) begin
          ctl.pc_jmp = neg_flag;
          ph_nxt     = PH_END;
        end else begin
          ph_nxt = PH_END;
        end
      end
      PH_EREAD: ph_nxt = PH_EMDR;
      PH_EMDR: begin
        ctl.mdr_mem = 1'b1;
        ph_nxt      = PH_EXEC;
      end
      PH_EXEC: begin
        if (is_load) begin
          ctl.acc_mem = 1'b1;
        end else begin
          ctl.acc_alu = 1'b1;
          ctl.flag_ld = 1'b1;
          ctl.alu_sub = is_sub;
        end
        ph_nxt = PH_END;
      end
      PH_EWRITE: begin
        mem_we = 1'b1;
        ph_nxt = PH_END;
      end
      PH_END:  ph_nxt = PH_FADDR;
      default: ph_nxt = PH_HALT;
    endcase
  end

  always_comb begin
    pend_nxt = irq | (pend & (ph != PH_END));
    halted   = (ph == PH_HALT);
    irq_ack  = (ph == PH_END) & pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_HALT;
      pend <= 1'b0;
    end else begin
      ph   <= ph_nxt;
      pend <= pend_nxt;
    end
  end

  // R9: a halted core stays halted until strobed
  p_halt_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted);

  // R10: acknowledge is a single-cycle pulse
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R5: a store drives exactly one write cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R9: leaving halt only happens through a strobe
  p_start_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> !ctl.pc_start || halted);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OP_W-1:0]   op,
  output logic              neg_flag
);

  logic [ADDR_W-1:0] pc, pc_nxt, mar, mar_nxt;
  logic [DATA_W-1:0] mdr, mdr_nxt, cir, acc, acc_nxt, alu_res;
  flags_t            flags, alu_fl;
  logic              pc_en, mar_en, mdr_en;
  logic [ADDR_W-1:0] opnd;

  acc_alu #(.W(DATA_W)) u_alu (
    .a   (acc),
    .b   (mdr),
    .sub (ctl.alu_sub),
    .res (alu_res),
    .fl  (alu_fl)
  );

  always_comb begin
    opnd    = cir[ADDR_W-1:0];
    pc_en   = ctl.pc_start | ctl.pc_inc | ctl.pc_jmp;
    if (ctl.pc_start)    pc_nxt = start_addr;
    else if (ctl.pc_jmp) pc_nxt = opnd;
    else                 pc_nxt = pc + 1'b1;
    mar_en  = ctl.mar_pc | ctl.mar_opnd;
    mar_nxt = ctl.mar_pc ? pc : opnd;
    mdr_en  = ctl.mdr_mem | ctl.mdr_acc;
    mdr_nxt = ctl.mdr_mem ? mem_rdata : acc;
    acc_nxt = ctl.acc_mem ? mdr : alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      cir   <= '0;
      acc   <= '0;
      flags <= '0;
    end else begin
      if (pc_en)                   pc    <= pc_nxt;
      if (mar_en)                  mar   <= mar_nxt;
      if (mdr_en)                  mdr   <= mdr_nxt;
      if (ctl.cir_ld)              cir   <= mdr;
      if (ctl.acc_mem | ctl.acc_alu) acc <= acc_nxt;
      if (ctl.flag_ld)             flags <= alu_fl;
    end
  end

  always_comb begin
    mem_addr  = mar;
    mem_wdata = mdr;
    op        = cir[DATA_W-1 -: OP_W];
    neg_flag  = flags.n;
  end

  // R1: the address latch takes the program counter in fetch
  p_mar_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mar_pc |=> mar == $past(pc));

  // R1: the instruction register is a copy of the data latch
  p_cir_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cir_ld |=> cir == $past(mdr));

  // R2: the program counter steps by one in fetch
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> pc == $past(pc) + 1'b1);

  // R7: flags hold unless an arithmetic result is written
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.flag_ld |=> $stable(flags));

  // R5: the written word is the accumulator
  p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == acc);

  // R8: a taken jump lands on the operand
  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_jmp |=> pc == $past(opnd));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic              irq_ack
);

  logic [1:0]      rst_q;
  logic            core_rst_n;
  ctl_t            ctl;
  logic [OP_W-1:0] op;
  logic            neg_flag;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  always_comb core_rst_n = rst_q[1];

  acc_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (start),
    .irq      (irq),
    .neg_flag (neg_flag),
    .op       (op),
    .ctl      (ctl),
    .mem_we   (mem_we),
    .halted   (halted),
    .irq_ack  (irq_ack)
  );

  acc_datapath #(.DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .ctl        (ctl),
    .mem_we     (mem_we),
    .start_addr (start_addr),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .op         (op),
    .neg_flag   (neg_flag)
  );

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] start_addr = '0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we, halted, irq_ack;

  always #2.5 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .irq(irq), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .irq_ack(irq_ack)
  );

  logic [15:0] mem [0:255];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  always @(posedge clk) begin
    if (ld_we)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  int ctr = 0;
  always @(posedge clk) ctr <= ctr + 1;

  int k0 = 0;
  int ack_total = 0;
  int ack_rel = 0;
  always @(negedge clk) if (irq_ack === 1'b1) begin
    ack_total = ack_total + 1;
    ack_rel   = ctr - k0;
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(int op, int adr);
    return {op[3:0], adr[11:0]};
  endfunction

  function automatic logic [15:0] val(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h1234;
      6: return 16'h00FF;
      default: return 16'h8001;
    endcase
  endfunction

  task automatic put(int a, logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_a = a[7:0]; ld_d = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // cycle 1 is the one after the edge that takes the strobe
  task automatic run(input int s, input int irq_at, input int start_at,
                     output int cyc, output logic early,
                     output logic [11:0] fa0, output logic [11:0] fa1,
                     output logic [11:0] fa2);
    int rel;
    @(negedge clk);
    start_addr = s[11:0];
    start = 1'b1;
    k0 = ctr;
    cyc = -1; early = 1'b1; fa0 = '0; fa1 = '0; fa2 = '0;
    for (int g = 0; g < 600; g++) begin
      @(negedge clk);
      rel   = ctr - k0;
      start = (rel == start_at);
      irq   = (rel == irq_at);
      if (rel == 1)  early = halted;
      if (rel == 2)  fa0 = mem_addr;
      if (rel == 6)  fa2 = mem_addr;
      if (rel == 11) fa1 = mem_addr;
      if (halted) begin
        cyc = rel;
        break;
      end
    end
    start = 1'b0;
    irq   = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc, s, acks;
    logic early;
    logic [11:0] fa0, fa1, fa2;
    logic [15:0] a, b, r;

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset halted", {31'd0, halted}, 32'd1);
    check("R9 reset no write", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 halted after release", {31'd0, halted}, 32'd1);
    check("R10 no ack idle", {31'd0, irq_ack}, 32'd0);

    // arithmetic and branch sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int m = 0; m < 2; m++) begin
          a = val(i); b = val(j);
          s = 16 * (1 + ((i + j + m) % 4));
          put(s + 0, ins(1, 128));
          put(s + 1, ins(m ? 4 : 3, 129));
          put(s + 2, ins(2, 130));
          put(s + 3, ins(6, s + 6));
          put(s + 4, ins(1, 133));
          put(s + 5, ins(5, s + 7));
          put(s + 6, ins(1, 134));
          put(s + 7, ins(2, 131));
          put(s + 8, ins(0, 0));
          put(128, a); put(129, b); put(130, 16'hDEAD); put(131, 16'h0);
          put(133, 16'h1); put(134, 16'h2);
          r = m ? (a - b) : (a + b);
          acks = ack_total;
          run(s, 0, 0, cyc, early, fa0, fa1, fa2);
          check("R6 sum/difference", {16'd0, mem[130]}, {16'd0, r});
          check("R8 branch path", {16'd0, mem[131]}, r[15] ? 32'd2 : 32'd1);
          check("R12 cycle count", cyc, r[15] ? 32'd53 : 32'd59);
          if (i == 0 && m == 0) begin
            check("R1 fetch address", {20'd0, fa0}, s);
            check("R2 next fetch address", {20'd0, fa1}, s + 1);
            check("R9 running after strobe", {31'd0, early}, 32'd0);
            check("R10 no spurious ack", ack_total - acks, 32'd0);
          end
        end
      end
    end

    // R3 R4 R5: full operand width, load then store
    put(80, ins(1, 12'hF87)); put(81, ins(2, 136)); put(82, ins(0, 0));
    put(135, 16'hBEEF); put(136, 16'h0); put(137, 16'h5555);
    run(80, 0, 0, cyc, early, fa0, fa1, fa2);
    check("R3 operand on bus", {20'd0, fa2}, 32'hF87);
    check("R4 loaded value stored", {16'd0, mem[136]}, 32'hBEEF);
    check("R5 neighbour untouched", {16'd0, mem[137]}, 32'h5555);
    check("R12 load+store+halt", cyc, 32'd22);

    // R7 R11 R9: load keeps negative flag, no-op, strobe while running
    put(112, ins(1, 128)); put(113, ins(4, 129)); put(114, ins(1, 133));
    put(115, 16'h7000);    put(116, ins(6, 119)); put(117, ins(5, 120));
    put(118, 16'h0);       put(119, ins(1, 134)); put(120, ins(2, 131));
    put(121, ins(0, 0));
    put(128, 16'd5); put(129, 16'd9); put(131, 16'h0);
    put(133, 16'h1); put(134, 16'h2);
    run(112, 0, 20, cyc, early, fa0, fa1, fa2);
    check("R7 flag kept over load", {16'd0, mem[131]}, 32'd2);
    check("R11 no-op length", cyc, 32'd61);
    check("R9 strobe ignored", {31'd0, halted}, 32'd1);

    // R10: interrupt boundaries
    put(96, ins(1, 135)); put(97, ins(1, 135)); put(98, ins(0, 0));
    acks = ack_total;
    run(96, 2, 0, cyc, early, fa0, fa1, fa2);
    check("R10 one ack", ack_total - acks, 32'd1);
    check("R10 ack at end of instr 1", ack_rel, 32'd9);
    check("R12 two loads", cyc, 32'd24);
    acks = ack_total;
    run(96, 9, 0, cyc, early, fa0, fa1, fa2);
    check("R10 deferred one ack", ack_total - acks, 32'd1);
    check("R10 ack at end of instr 2", ack_rel, 32'd18);
    acks = ack_total;
    run(96, 0, 0, cyc, early, fa0, fa1, fa2);
    check("R10 quiet run", ack_total - acks, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule